// File: doc/BRIEF.md
# Load-Scatter Register Quarter Writer

This block takes one 32-byte memory load and spreads it over a destination operand of one, two or four consecutive 256-bit coprocessor registers. The load is cut into four 64-bit blocks, and each block lands in one selected quarter of one register of the operand. The load is not copied linearly into a register. It is transposed, so one 64-bit slice goes into the same quarter of successive registers. Four loads that use the four quarter selectors therefore assemble a four-row tile, taken from a row-major matrix, in a register group.

The block decodes each load into per-register write enables and per-quarter lane masks. It drives these into a small register file that it holds internally. A combinational read port exposes any register's contents. A write commits on the rising edge that samples the valid strobe. There is no back-pressure.

Top module: `ls_scatter_writer`

## Requirements
- R1: Reset (rst high, synchronous) clears every register of the file to zero.
- R2: With span code 2'b10 (four registers), block k (load bits 64k+63:64k) is written to quarter q (register bits 64q+63:64q) of register (base+k) mod NREGS, where q is the quarter selector.
- R3: With span code 2'b01 (two registers), block k is written to register (base + (k mod 2)) mod NREGS at quarter (q + k/2) mod 4.
- R4: With span code 2'b00 (one register), block k is written to quarter (q + k) mod 4 of register base.
- R5: Quarters and registers not targeted by a load keep their previous contents.
- R6: When ld_valid is low, or the span code is 2'b11, nothing is written, and wr_en and wr_lanes are all zero.
- R7: A write becomes visible on rd_data just after the rising edge that samples ld_valid high. Before that edge, the old contents are shown. rd_data is a combinational read of register rd_idx.
- R8: Bit 4r+j of wr_lanes means quarter j of register r is written in this cycle, and bit r of wr_en means register r is written. An accepted load sets exactly four wr_lanes bits, and it sets 1, 2 or 4 wr_en bits for span codes 2'b00, 2'b01 and 2'b10.
- R9: After four span-4 loads at the same base with q = 0, 1, 2, 3, quarter q of register base+k holds block k of the load issued with selector q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_data | input | 256 | The 32 loaded bytes; block k is bits 64k+63:64k |
| ld_quarter | input | 2 | Quarter selector (instruction variant) |
| ld_base | input | IDX_W (3) | First register of the destination operand |
| ld_size | input | 2 | Span code: 00 one, 01 two, 10 four registers, 11 reserved |
| rd_idx | input | IDX_W (3) | Register index for the read port |
| rd_data | output | 256 | Contents of register rd_idx |
| wr_en | output | NREGS (8) | Per-register write enable in this cycle |
| wr_lanes | output | 4*NREGS (32) | Per-quarter write mask, bit 4r+j for register r quarter j |

## Verification
The assertions check on every cycle that an idle or reserved-span cycle writes nothing, and that an accepted load marks exactly four quarters across the right number of registers. In four-register mode, they check that each enabled register takes a single quarter. They also check that the read port holds still when no write and no index change occurred. Only the bench's scenarios can show that each block lands in the right register and quarter with the right data. The same applies to wrap-around of the register and quarter indices, to untouched quarters keeping old data across mixed spans, and to the four-load tile assembly.

// File: rtl/ls_pkg.sv
`timescale 1ns/1ps
package ls_pkg;
    localparam int NUM_Q = 4;

    typedef enum logic [1:0] {
        SPAN_ONE  = 2'b00,
        SPAN_TWO  = 2'b01,
        SPAN_FOUR = 2'b10,
        SPAN_BAD  = 2'b11
    } span_e;

    typedef struct packed {
        logic [1:0] reg_off;
        logic [1:0] quarter;
    } slot_t;

    // Where block blk of a load lands, relative to the operand base.
    function automatic slot_t place_block(input logic [1:0] blk, input span_e span,
                                          input logic [1:0] q);
        slot_t s;
        case (span)
            SPAN_ONE: begin
                s.reg_off = 2'd0;
                s.quarter = q + blk;
            end
            SPAN_TWO: begin
                s.reg_off = {1'b0, blk[0]};
                s.quarter = q + {1'b0, blk[1]};
            end
            default: begin
                s.reg_off = blk;
                s.quarter = q;
            end
        endcase
        return s;
    endfunction

    function automatic logic span_ok(input span_e span);
        return span != SPAN_BAD;
    endfunction
endpackage

// File: rtl/ls_route.sv
`timescale 1ns/1ps
module ls_route
    import ls_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int REG_W = 256
) (
    input  logic                              valid,
    input  logic [REG_W-1:0]                  data,
    input  logic [1:0]                        quarter,
    input  logic [IDX_W-1:0]                  base,
    input  span_e                             span,
    output logic [(1<<IDX_W)-1:0]             wr_en,
    output logic [(1<<IDX_W)*NUM_Q-1:0]       lanes,
    output logic [(1<<IDX_W)-1:0][REG_W-1:0]  wdata
);
    localparam int BLK_W = REG_W / NUM_Q;

    slot_t            slot;
    logic [IDX_W-1:0] idx;

    always_comb begin
        wr_en = '0;
        lanes = '0;
        wdata = '0;
        slot  = '0;
        idx   = '0;
        if (valid && span_ok(span)) begin
            for (int k = 0; k < NUM_Q; k++) begin
                slot = place_block(2'(k), span, quarter);
                idx  = base + IDX_W'(slot.reg_off);
                wr_en[idx] = 1'b1;
                lanes[int'(idx)*NUM_Q + int'(slot.quarter)] = 1'b1;
                wdata[idx][int'(slot.quarter)*BLK_W +: BLK_W] = data[k*BLK_W +: BLK_W];
            end
        end
    end
endmodule

// File: rtl/ls_regfile.sv
`timescale 1ns/1ps
module ls_regfile
    import ls_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int REG_W = 256
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [(1<<IDX_W)*NUM_Q-1:0]       lanes,
    input  logic [(1<<IDX_W)-1:0][REG_W-1:0]  wdata,
    input  logic [IDX_W-1:0]                  rd_idx,
    output logic [REG_W-1:0]                  rd_data
);
    localparam int NREGS = 1 << IDX_W;
    localparam int BLK_W = REG_W / NUM_Q;

    logic [NREGS-1:0][REG_W-1:0] regs_q;

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        for (genvar j = 0; j < NUM_Q; j++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs_q[r][j*BLK_W +: BLK_W] <= '0;
                end else if (lanes[r*NUM_Q + j]) begin
                    regs_q[r][j*BLK_W +: BLK_W] <= wdata[r][j*BLK_W +: BLK_W];
                end
            end
        end
    end

    assign rd_data = regs_q[rd_idx];
endmodule

// File: rtl/ls_scatter_writer.sv
`timescale 1ns/1ps
module ls_scatter_writer
    import ls_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int REG_W = 256,
    localparam int NREGS = 1 << IDX_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ld_valid,
    input  logic [REG_W-1:0]       ld_data,
    input  logic [1:0]             ld_quarter,
    input  logic [IDX_W-1:0]       ld_base,
    input  logic [1:0]             ld_size,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [REG_W-1:0]       rd_data,
    output logic [NREGS-1:0]       wr_en,
    output logic [NREGS*NUM_Q-1:0] wr_lanes
);
    logic [NREGS-1:0][REG_W-1:0] wdata;

    ls_route #(.IDX_W(IDX_W), .REG_W(REG_W)) route_i (
        .valid   (ld_valid),
        .data    (ld_data),
        .quarter (ld_quarter),
        .base    (ld_base),
        .span    (span_e'(ld_size)),
        .wr_en   (wr_en),
        .lanes   (wr_lanes),
        .wdata   (wdata)
    );

    ls_regfile #(.IDX_W(IDX_W), .REG_W(REG_W)) file_i (
        .clk     (clk),
        .rst     (rst),
        .lanes   (wr_lanes),
        .wdata   (wdata),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/ls_scatter_checker.sv
`timescale 1ns/1ps
module ls_scatter_checker #(
    parameter int IDX_W = 3,
    parameter int REG_W = 256,
    localparam int NREGS = 1 << IDX_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 ld_valid,
    input logic [1:0]           ld_size,
    input logic [IDX_W-1:0]     rd_idx,
    input logic [REG_W-1:0]     rd_data,
    input logic [NREGS-1:0]     wr_en,
    input logic [NREGS*4-1:0]   wr_lanes
);
    logic accepted;
    assign accepted = ld_valid && (ld_size != 2'b11);

    assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !accepted |-> (wr_en == '0 && wr_lanes == '0));

    assert_lane_count_R8: assert property (@(posedge clk) disable iff (rst)
        accepted |-> $countones(wr_lanes) == 4);

    assert_reg_count_R8: assert property (@(posedge clk) disable iff (rst)
        accepted |-> $countones(wr_en) == (1 << ld_size));

    for (genvar r = 0; r < NREGS; r++) begin : g_chk
        assert_one_quarter_R2: assert property (@(posedge clk) disable iff (rst)
            (accepted && ld_size == 2'b10 && wr_en[r]) |-> $countones(wr_lanes[r*4 +: 4]) == 1);
    end

    // R5: without a write or index change, the read port holds
    assert_read_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ld_valid) && $stable(rd_idx)) |-> $stable(rd_data));
endmodule

bind ls_scatter_writer ls_scatter_checker #(.IDX_W(IDX_W), .REG_W(REG_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .ld_valid (ld_valid),
    .ld_size  (ld_size),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_lanes (wr_lanes)
);

// File: tb/ls_scatter_writer_tb.sv
`timescale 1ns/1ps
module ls_scatter_writer_tb_top;
    localparam int IDX_W = 3;
    localparam int NR = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ld_valid = 1'b0;
    logic [255:0] ld_data = '0;
    logic [1:0] ld_quarter = '0;
    logic [IDX_W-1:0] ld_base = '0;
    logic [1:0] ld_size = '0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [255:0] rd_data;
    logic [NR-1:0] wr_en;
    logic [NR*4-1:0] wr_lanes;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [255:0] model [NR];

    always #2.5 clk = ~clk;

    ls_scatter_writer #(.IDX_W(IDX_W)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] mk(input int seed);
        logic [255:0] d;
        for (int k = 0; k < 4; k++)
            d[k*64 +: 64] = {32'hC0DE0000 + 32'(seed), 32'h0000B000 + 32'(k)};
        return d;
    endfunction

    task automatic check_all(input string req);
        for (int r = 0; r < NR; r++) begin
            rd_idx = IDX_W'(r);
            #0.2;
            chk(rd_data === model[r], req, rd_data, model[r]);
        end
    endtask

    task automatic do_load(input logic [1:0] q, input int base, input logic [1:0] sz,
                           input int seed, input string req);
        logic [255:0] d;
        logic [NR-1:0] exp_en;
        logic [NR*4-1:0] exp_ln;
        d = mk(seed);
        exp_en = '0;
        exp_ln = '0;
        @(negedge clk);
        ld_valid = 1'b1; ld_data = d; ld_quarter = q;
        ld_base = IDX_W'(base); ld_size = sz;
        #0.5;
        if (sz != 2'b11) begin
            for (int k = 0; k < 4; k++) begin
                int n = 1 << sz;
                int r = (base + (k % n)) % NR;
                int qq = (int'(q) + k / n) % 4;
                exp_en[r] = 1'b1;
                exp_ln[r*4 + qq] = 1'b1;
                model[r][qq*64 +: 64] = d[k*64 +: 64];
            end
        end
        chk(wr_lanes === exp_ln, {req, "/R8 lanes"}, 256'(wr_lanes), 256'(exp_ln));
        chk(wr_en === exp_en, {req, "/R8 enables"}, 256'(wr_en), 256'(exp_en));
        @(negedge clk);
        ld_valid = 1'b0;
        check_all(req);
    endtask

    task automatic t_reset;
        for (int r = 0; r < NR; r++) model[r] = '0;
        check_all("R1 reset");
    endtask

    task automatic t_four;
        do_load(2'd1, 2, 2'b10, 1, "R2 span4");
        do_load(2'd3, 6, 2'b10, 2, "R2 span4 wrap");
    endtask

    task automatic t_two;
        do_load(2'd0, 3, 2'b01, 3, "R3 span2 q0");
        do_load(2'd2, 3, 2'b01, 4, "R3 span2 q2");
        do_load(2'd3, 7, 2'b01, 5, "R3 span2 wrap");
    endtask

    task automatic t_one;
        do_load(2'd0, 5, 2'b00, 6, "R4 span1 q0");
        do_load(2'd2, 4, 2'b00, 7, "R4 span1 q2 wrap");
        check_all("R5 untouched after mixed spans");
    endtask

    task automatic t_idle;
        @(negedge clk);
        ld_valid = 1'b0; ld_data = mk(9); ld_size = 2'b10; ld_base = '0;
        #0.5;
        chk(wr_en === '0 && wr_lanes === '0, "R6 idle strobes", 256'(wr_lanes), '0);
        @(negedge clk);
        check_all("R6 idle no write");
        do_load(2'd0, 1, 2'b11, 10, "R6 reserved span");
    endtask

    task automatic t_timing;
        logic [255:0] d;
        logic [255:0] old;
        d = mk(11);
        rd_idx = 3'd0;
        @(negedge clk);
        old = model[0];
        ld_valid = 1'b1; ld_data = d; ld_quarter = 2'd1; ld_base = 3'd0; ld_size = 2'b00;
        #1;
        chk(rd_data === old, "R7 before edge", rd_data, old);
        for (int k = 0; k < 4; k++) model[0][((1 + k) % 4)*64 +: 64] = d[k*64 +: 64];
        @(posedge clk);
        #0.5;
        chk(rd_data === model[0], "R7 after edge", rd_data, model[0]);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic t_tile;
        for (int q = 0; q < 4; q++) do_load(2'(q), 4, 2'b10, 20 + q, "R9 tile load");
        for (int k = 0; k < 4; k++) begin
            rd_idx = IDX_W'(4 + k);
            #0.2;
            for (int q = 0; q < 4; q++) begin
                logic [255:0] src;
                src = mk(20 + q);
                chk(rd_data[q*64 +: 64] === src[k*64 +: 64], "R9 tile cell",
                    256'(rd_data[q*64 +: 64]), 256'(src[k*64 +: 64]));
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_four();
        t_two();
        t_one();
        t_idle();
        t_timing();
        t_tile();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule